// File: doc/BRIEF.md
# Modem Handshake Control and Status Register Block

This block sits beside a serial transmitter and receiver and owns the modem handshake lines. A control register, written through a write strobe, drives the four handshake outputs (terminal ready, request to send and two general-purpose outputs). The second general-purpose output also serves as the interrupt enable for the rest of the serial controller. The four handshake inputs (clear to send, data set ready, ring indicator, carrier detect) are synchronized. Their current levels are reported in a status byte together with four sticky change flags. The change flags clear when the status byte is read, and any set flag raises a modem-status interrupt request.

A loopback bit in the control register turns the block into a self-test path. The external handshake outputs are forced inactive and the external serial output idles high. The transmit shift-register output is fed straight back to the receiver input. The four low control bits replace the external handshake inputs as the source of the status levels. Software can then exercise the status path and the serial datapath without any cable.

Top module: `modem_ctl_stat`

## Requirements
- R1: While `rst` is high at a clock edge, `ctl_rdata`, `stat_rdata`, all four handshake outputs, `irq_en_o` and `msi_req_o` are 0 from the following cycle on.
- R2: A write stores `wr_data[4:0]` in the control register. Bit 0 is terminal ready, bit 1 request to send, bit 2 general output 1, bit 3 general output 2 and bit 4 loopback enable. `ctl_rdata[7:5]` always reads 0, and `irq_en_o` follows control bit 3 in every mode.
- R3: The status byte holds change flags in bits 3..0 and current levels in bits 7..4. In each nibble clear-to-send is the lowest bit, then data-set-ready, ring indicator, and carrier detect highest.
- R4: Outside loopback, an external input change is not visible after two rising edges. It appears in the status levels after the third rising edge that follows it.
- R5: A change flag is set by any change of its level, rising or falling. It stays set until the status byte is read, even if the level returns.
- R6: Asserting `stat_rd` for one cycle returns the pre-clear status byte in that cycle. All change flags are 0 in the next cycle unless R7 applies.
- R7: A level change that is registered at the same edge as a status read sets its change flag in spite of the read.
- R8: In loopback, the status levels are control bits 0..3 (clear to send from bit 0, data set ready from bit 1, ring indicator from bit 2, carrier detect from bit 3), one edge after the control write. The external handshake inputs have no effect.
- R9: In loopback, `ser_tx_o` is 1 and `ser_rx_o` equals `ser_tx_i`. Otherwise `ser_tx_o` equals `ser_tx_i` and `ser_rx_o` equals `ser_rx_i`.
- R10: In loopback, all four handshake outputs are 0. Outside loopback, they equal control bits 0..3.
- R11: `msi_req_o` is 1 exactly when at least one change flag is set.
- R12: Entering or leaving loopback sets the change flag of every level whose value differs between the old and the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control write data |
| stat_rd | input | 1 | Status read strobe, clears change flags |
| ctl_rdata | output | 8 | Control register read value |
| stat_rdata | output | 8 | Status byte (levels high, change flags low) |
| cts_i | input | 1 | External clear-to-send level |
| dsr_i | input | 1 | External data-set-ready level |
| ri_i | input | 1 | External ring indicator level |
| dcd_i | input | 1 | External carrier detect level |
| dtr_o | output | 1 | Terminal ready output |
| rts_o | output | 1 | Request to send output |
| out1_o | output | 1 | General-purpose output 1 |
| out2_o | output | 1 | General-purpose output 2 |
| ser_tx_i | input | 1 | Transmit shift-register output |
| ser_tx_o | output | 1 | Serial output pin |
| ser_rx_i | input | 1 | Serial input pin |
| ser_rx_o | output | 1 | Serial input to the receiver |
| irq_en_o | output | 1 | Interrupt enable (control bit 3) |
| msi_req_o | output | 1 | Modem-status interrupt request |

## Verification
A status read that clears the change flags can share an edge with a newly registered level change. The bench provokes this by timing an input change so that its third synchronizer edge is the read edge. It judges the result by the flags seen afterwards: the new change survives and older flags are gone. The same collision is repeated with a stale flag already set in another bit. This shows that the clear and the set act on different bits within one cycle.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    localparam int HS_W   = 4;
    localparam int BYTE_W = 8;

    typedef logic [HS_W-1:0] hs_t;

    typedef struct packed {
        logic loop;
        logic gp2;
        logic gp1;
        logic req;
        logic rdy;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic [BYTE_W-1:0] ctl_byte(input ctl_t c);
        return {{(BYTE_W-CTL_W){1'b0}}, c};
    endfunction

    function automatic logic [BYTE_W-1:0] stat_byte(input hs_t lvl, input hs_t chg);
        return {lvl, chg};
    endfunction

    function automatic hs_t ctl_hs(input ctl_t c);
        return {c.gp2, c.gp1, c.req, c.rdy};
    endfunction
endpackage

// File: rtl/mcs_ctl_reg.sv
module mcs_ctl_reg
    import mcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    output ctl_t              ctl_q
);
    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (wr_en)
            ctl_q <= ctl_t'(wr_byte[CTL_W-1:0]);
    end
endmodule

// File: rtl/mcs_sync.sv
module mcs_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mcs_delta.sv
module mcs_delta
    import mcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  hs_t  src,
    input  logic clr,
    output hs_t  lvl_q,
    output hs_t  chg_q
);
    hs_t chg_d;

    always_comb begin
        chg_d = (clr ? '0 : chg_q) | (src ^ lvl_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            chg_q <= '0;
        end else begin
            lvl_q <= src;
            chg_q <= chg_d;
        end
    end
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
    import mcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  logic [7:0] wr_data,
    input  logic       stat_rd,
    output logic [7:0] ctl_rdata,
    output logic [7:0] stat_rdata,
    input  logic       cts_i,
    input  logic       dsr_i,
    input  logic       ri_i,
    input  logic       dcd_i,
    output logic       dtr_o,
    output logic       rts_o,
    output logic       out1_o,
    output logic       out2_o,
    input  logic       ser_tx_i,
    output logic       ser_tx_o,
    input  logic       ser_rx_i,
    output logic       ser_rx_o,
    output logic       irq_en_o,
    output logic       msi_req_o
);
    ctl_t ctl_q;
    hs_t  ext_raw, ext_sync, lvl_src, lvl_q, chg_q;

    mcs_ctl_reg u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctl_wr),
        .wr_byte (wr_data),
        .ctl_q   (ctl_q)
    );

    assign ext_raw = {dcd_i, ri_i, dsr_i, cts_i};

    mcs_sync #(.W(HS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_raw),
        .q   (ext_sync)
    );

    // Loopback swaps the level source before change detection.
    assign lvl_src = ctl_q.loop ? ctl_hs(ctl_q) : ext_sync;

    mcs_delta u_delta (
        .clk   (clk),
        .rst   (rst),
        .src   (lvl_src),
        .clr   (stat_rd),
        .lvl_q (lvl_q),
        .chg_q (chg_q)
    );

    assign ctl_rdata  = ctl_byte(ctl_q);
    assign stat_rdata = stat_byte(lvl_q, chg_q);

    assign dtr_o  = ctl_q.rdy & ~ctl_q.loop;
    assign rts_o  = ctl_q.req & ~ctl_q.loop;
    assign out1_o = ctl_q.gp1 & ~ctl_q.loop;
    assign out2_o = ctl_q.gp2 & ~ctl_q.loop;

    assign ser_tx_o = ctl_q.loop ? 1'b1 : ser_tx_i;
    assign ser_rx_o = ctl_q.loop ? ser_tx_i : ser_rx_i;

    assign irq_en_o  = ctl_q.gp2;
    assign msi_req_o = |chg_q;
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker (
    input logic       clk,
    input logic       rst,
    input logic       stat_rd,
    input logic [7:0] ctl_rdata,
    input logic [7:0] stat_rdata,
    input logic       dtr_o,
    input logic       rts_o,
    input logic       out1_o,
    input logic       out2_o,
    input logic       ser_tx_i,
    input logic       ser_tx_o,
    input logic       ser_rx_i,
    input logic       ser_rx_o,
    input logic       msi_req_o
);
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[7:5] == 3'b000);

    a_r5_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> ((stat_rdata[3:0] & $past(stat_rdata[3:0])) == $past(stat_rdata[3:0])));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> (!$stable(stat_rdata[7:4]) || stat_rdata[3:0] == 4'b0000));

    a_r7_change_flagged: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_rdata[3:0] & (stat_rdata[7:4] ^ $past(stat_rdata[7:4])))
                  == (stat_rdata[7:4] ^ $past(stat_rdata[7:4]))));

    a_r9_loop_serial: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[4] |-> (ser_tx_o && ser_rx_o == ser_tx_i));

    a_r9_pass_serial: assert property (@(posedge clk) disable iff (rst)
        !ctl_rdata[4] |-> (ser_tx_o == ser_tx_i && ser_rx_o == ser_rx_i));

    a_r10_loop_quiet: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[4] |-> !(dtr_o || rts_o || out1_o || out2_o));

    a_r11_request: assert property (@(posedge clk) disable iff (rst)
        msi_req_o == (stat_rdata[3:0] != 4'b0000));
endmodule

bind modem_ctl_stat mcs_checker u_chk (.*);

// File: tb/modem_ctl_stat_tb.sv
module modem_ctl_stat_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst = 1'b1, ctl_wr = 1'b0, stat_rd = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] ctl_rdata, stat_rdata;
    logic cts_i = 0, dsr_i = 0, ri_i = 0, dcd_i = 0;
    logic dtr_o, rts_o, out1_o, out2_o;
    logic ser_tx_i = 0, ser_rx_i = 0, ser_tx_o, ser_rx_o;
    logic irq_en_o, msi_req_o;

    int checks = 0, fails = 0;
    bit done = 0;

    modem_ctl_stat u_dut (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_ext(input logic [3:0] v);
        {dcd_i, ri_i, dsr_i, cts_i} = v;
    endtask

    task automatic wr_ctl(input logic [7:0] b);
        ctl_wr = 1'b1; wr_data = b;
        step();
        ctl_wr = 1'b0;
    endtask

    task automatic rd_stat(output logic [7:0] v);
        stat_rd = 1'b1;
        v = stat_rdata;
        step();
        stat_rd = 1'b0;
    endtask

    function automatic logic [7:0] hs_out();
        return {4'b0, out2_o, out1_o, rts_o, dtr_o};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [3:0] p, v, e, prev;
        step(3);
        // R1 reset state
        chk("R1 ctl", ctl_rdata, 8'h00);
        chk("R1 stat", stat_rdata, 8'h00);
        chk("R1 outs", {hs_out()[3:0], irq_en_o, msi_req_o, 2'b0}, 8'h00);
        rst = 1'b0;
        step();

        // R2 / R10 control write outside loopback
        for (int n = 0; n < 16; n++) begin
            wr_ctl({3'b111, 1'b0, n[3:0]});
            chk("R2 ctl readback", ctl_rdata, {4'b0, n[3:0]});
            chk("R10 outputs follow", hs_out(), {4'b0, n[3:0]});
            chk("R2 irq enable", {7'b0, irq_en_o}, {7'b0, n[3]});
            chk("R2 status untouched", stat_rdata, 8'h00);
        end
        wr_ctl(8'h00);

        // R3 R4 R5 R6 R11 sweep of all external patterns
        p = 4'h0;
        for (int k = 1; k <= 16; k++) begin
            v = 4'((k * 7) % 16);
            set_ext(v);
            step(2);
            chk("R4 not yet visible", stat_rdata, {p, 4'b0});
            step(1);
            chk("R3 R5 levels and flags", stat_rdata, {v, p ^ v});
            chk("R11 request", {7'b0, msi_req_o}, {7'b0, |(p ^ v)});
            rd_stat(r);
            chk("R6 read value", r, {v, p ^ v});
            chk("R6 cleared", stat_rdata, {v, 4'b0});
            p = v;
        end

        // R5 flag survives a return of the level
        set_ext(p ^ 4'b0100); step(3);
        set_ext(p); step(3);
        chk("R5 sticky", stat_rdata, {p, 4'b0100});
        rd_stat(r);

        // R7 change lands on the read edge
        v = p ^ 4'b0110;
        set_ext(v); step(2);
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
        chk("R7 kept", stat_rdata, {v, 4'b0110});
        rd_stat(r); p = v;

        // R7 with an older flag in another bit
        v = p ^ 4'b0001; set_ext(v); step(3); p = v;
        v = p ^ 4'b1000; set_ext(v); step(2);
        rd_stat(r);
        chk("R7 read value", r, {p, 4'b0001});
        chk("R7 old cleared new kept", stat_rdata, {v, 4'b1000});
        rd_stat(r); p = v;
        e = p;

        // R8 R12 R10 loopback sweep
        prev = e;
        for (int n = 0; n < 16; n++) begin
            wr_ctl({4'b0001, n[3:0]});
            chk("R2 loop readback", ctl_rdata, {4'b0001, n[3:0]});
            step();
            chk("R8 R12 loop levels", stat_rdata, {n[3:0], prev ^ n[3:0]});
            chk("R10 outputs inactive", hs_out(), 8'h00);
            chk("R2 irq enable loop", {7'b0, irq_en_o}, {7'b0, n[3]});
            rd_stat(r);
            prev = n[3:0];
        end
        // R8 external inputs ignored
        set_ext(~e); step(4);
        chk("R8 ext ignored", stat_rdata, {prev, 4'b0});

        // R9 serial in loopback
        for (int m = 0; m < 4; m++) begin
            ser_tx_i = m[0]; ser_rx_i = m[1]; #1;
            chk("R9 loop serial", {6'b0, ser_tx_o, ser_rx_o}, {6'b0, 1'b1, m[0]});
        end

        // R12 leaving loopback
        wr_ctl(8'h00); step();
        chk("R12 exit levels", stat_rdata, {~e, prev ^ ~e});
        rd_stat(r);
        for (int m = 0; m < 4; m++) begin
            ser_tx_i = m[0]; ser_rx_i = m[1]; #1;
            chk("R9 pass serial", {6'b0, ser_tx_o, ser_rx_o}, {6'b0, m[0], m[1]});
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule